// File: doc/BRIEF.md
# Handshaked Byte Shift Transceiver

This block moves one byte at a time between a host and a peer microcontroller over a serial link. The peer owns the shift clock. The host frames each byte with an active-low request line, and the peer answers on an active-low acknowledge line. The host raises a one-cycle start strobe together with a direction and, for sends, a byte. The block arms its shift register, pulls the request line low, and shifts one bit for every rising edge of the peer's clock.

After eight edges the block releases the request line. For an inbound transfer it also captures the received byte. It then waits for the acknowledge line to return high before it reports the byte as complete. If the acknowledge line stays low past a parameterised bound, the block raises an error pulse instead and returns to idle. Command framing, queuing and interrupt decoding belong to the layers above.

Top module: `byte_link_xcvr`

## Requirements
- R1: After reset, req_n_o is 1, idle_o is 1, sdata_oe_o is 0, and done_o, warn_o and err_o are 0.
- R2: A start_i pulse is accepted only while idle_o is 1. A start_i raised while a transfer is in progress has no effect on that transfer's data or outcome.
- R3: Within a few cycles of an accepted start, req_n_o goes to 0 and stays 0 until the eighth shift.
- R4: For an outbound transfer (dir_out_i = 1), sdata_oe_o is 1 while bits are shifting. sdata_o presents the byte most significant bit first, and it advances to the next bit after each synchronised rising edge of sclk_i.
- R5: For an inbound transfer (dir_out_i = 0), the register starts cleared. sdata_i is sampled on each synchronised rising edge of sclk_i, most significant bit first. When done_o pulses, rx_byte_o holds the eight sampled bits.
- R6: An outbound transfer leaves rx_byte_o unchanged.
- R7: After the eighth rising edge, req_n_o returns to 1.
- R8: done_o is a single-cycle pulse. It occurs only after ack_n_i has been seen high following the release of the request, and idle_o is 1 in the next cycle.
- R9: If ack_n_i is already high (not acknowledging) when the eighth edge completes the byte, warn_o pulses for one cycle.
- R10: If ack_n_i stays low for TIMEOUT_CYC cycles after the request is released, err_o pulses for one cycle, done_o does not pulse for that transfer, and the block returns to idle.
- R11: Rising edges on sclk_i while the block is idle are ignored and do not disturb the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle strobe that begins a transfer |
| dir_out_i | input | 1 | 1 = send tx_byte_i, 0 = receive |
| tx_byte_i | input | 8 | Byte to send |
| idle_o | output | 1 | Block can accept a start |
| done_o | output | 1 | One-cycle pulse when a byte completes |
| rx_byte_o | output | 8 | Last byte received |
| warn_o | output | 1 | Pulse: acknowledge not asserted at byte end |
| err_o | output | 1 | Pulse: acknowledge did not release in time |
| sclk_i | input | 1 | Shift clock from the peer |
| sdata_i | input | 1 | Serial data from the peer |
| sdata_o | output | 1 | Serial data to the peer |
| sdata_oe_o | output | 1 | Drive enable for sdata_o |
| req_n_o | output | 1 | Active-low transfer request |
| ack_n_i | input | 1 | Active-low acknowledge from the peer |

## Verification
The properties assume the peer's clock phases each last well beyond the two-flop synchroniser delay. They also assume that start_i is a single-cycle strobe. The bench's peer model holds each clock phase for four system cycles. It changes sdata_i only in the low phase and reads sdata_o just before raising the clock. The bench drives start_i as a single-cycle pulse, including the stray pulse sent during a busy transfer.

// File: rtl/byte_link_pkg.sv
package byte_link_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_WAIT  = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/byte_link_sync.sv
module byte_link_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    input  logic [WIDTH-1:0] rst_val_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= rst_val_i;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/byte_link_shifter.sv
module byte_link_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [BITS-1:0] load_val_i,
    input  logic            shift_i,
    input  logic            bit_i,
    output logic [BITS-1:0] q_o
);
    logic [BITS-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i)       sh_d = load_val_i;
        else if (shift_i) sh_d = {sh_q[BITS-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q;
endmodule

// File: rtl/byte_link_xcvr.sv
module byte_link_xcvr
    import byte_link_pkg::*;
#(
    parameter int BITS        = 8,
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 3_200_000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            dir_out_i,
    input  logic [BITS-1:0] tx_byte_i,
    output logic            idle_o,
    output logic            done_o,
    output logic [BITS-1:0] rx_byte_o,
    output logic            warn_o,
    output logic            err_o,
    input  logic            sclk_i,
    input  logic            sdata_i,
    output logic            sdata_o,
    output logic            sdata_oe_o,
    output logic            req_n_o,
    input  logic            ack_n_i
);
    localparam int CNT_W = (BITS > 1) ? $clog2(BITS) : 1;
    localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS - 1);
    localparam logic [TMR_W-1:0] TMR_END  = TMR_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        xfer_state_e     st;
        logic            dir_out;
        logic [CNT_W-1:0] bits;
        logic [TMR_W-1:0] tmr;
        logic            req_n;
        logic            done;
        logic            warn;
        logic            err;
        logic            sclk_prev;
        logic [BITS-1:0] rx;
    } xcvr_regs_t;

    xcvr_regs_t r_d, r_q;

    // synchronised peer signals: {sclk, sdata, ack_n}
    logic [2:0] link_s;
    logic       sclk_s, sdata_s, ack_s;

    byte_link_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_i   ({sclk_i, sdata_i, ack_n_i}),
        .rst_val_i (3'b001),
        .sync_o    (link_s)
    );
    assign {sclk_s, sdata_s, ack_s} = link_s;

    logic            sh_load, sh_shift, sh_in;
    logic [BITS-1:0] sh_q;
    logic [BITS-1:0] sh_load_val;
    logic            clk_rise;

    byte_link_shifter #(.BITS(BITS)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sh_load),
        .load_val_i (sh_load_val),
        .shift_i    (sh_shift),
        .bit_i      (sh_in),
        .q_o        (sh_q)
    );

    assign clk_rise    = sclk_s & ~r_q.sclk_prev;
    assign sh_load_val = dir_out_i ? tx_byte_i : '0;
    assign sh_in       = r_q.dir_out ? 1'b0 : sdata_s;

    always_comb begin
        r_d           = r_q;
        r_d.done      = 1'b0;
        r_d.warn      = 1'b0;
        r_d.err       = 1'b0;
        r_d.sclk_prev = sclk_s;
        sh_load       = 1'b0;
        sh_shift      = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st      = ST_SHIFT;
                    r_d.dir_out = dir_out_i;
                    r_d.bits    = '0;
                    r_d.req_n   = 1'b0;
                    sh_load     = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (clk_rise) begin
                    sh_shift = 1'b1;
                    if (r_q.bits == LAST_BIT) begin
                        r_d.st    = ST_WAIT;
                        r_d.req_n = 1'b1;
                        r_d.tmr   = '0;
                        r_d.warn  = ack_s;
                        if (!r_q.dir_out) r_d.rx = {sh_q[BITS-2:0], sdata_s};
                    end else begin
                        r_d.bits = r_q.bits + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (ack_s) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if (r_q.tmr == TMR_END) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.st        <= ST_IDLE;
            r_q.req_n     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign idle_o     = (r_q.st == ST_IDLE);
    assign done_o     = r_q.done;
    assign warn_o     = r_q.warn;
    assign err_o      = r_q.err;
    assign rx_byte_o  = r_q.rx;
    assign req_n_o    = r_q.req_n;
    assign sdata_o    = sh_q[BITS-1];
    assign sdata_oe_o = (r_q.st == ST_SHIFT) && r_q.dir_out;
endmodule

// File: rtl/byte_link_xcvr_chk.sv
module byte_link_xcvr_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic idle_o,
    input logic req_n_o,
    input logic done_o,
    input logic warn_o,
    input logic err_o,
    input logic sdata_oe_o
);
    a_r1_idle_req_high: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> req_n_o);

    a_r3_start_asserts_req: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && start_i) |=> !req_n_o);

    a_r4_oe_within_req: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_oe_o |-> !req_n_o);

    a_r7_release_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_n_o) |-> !idle_o);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (req_n_o && idle_o));

    a_r9_warn_single: assert property (@(posedge clk) disable iff (!rst_n)
        warn_o |=> !warn_o);

    a_r10_err_excludes_done: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !done_o);

    a_r10_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);
endmodule

bind byte_link_xcvr byte_link_xcvr_chk u_chk (.*);

// File: tb/sim_byte_link_xcvr.sv
module sim_byte_link_xcvr;
    localparam int CLK_PERIOD = 10;
    localparam int TO_CYC     = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, dir_out_i = 1'b0;
    logic [7:0] tx_byte_i = '0;
    logic       idle_o, done_o, warn_o, err_o;
    logic [7:0] rx_byte_o;
    logic       sclk_i = 1'b0, sdata_i = 1'b0, sdata_o, sdata_oe_o, req_n_o;
    logic       ack_n_i = 1'b1;

    int checks = 0, errors = 0;
    int n_done = 0, n_warn = 0, n_err = 0, n_oe = 0;
    logic [7:0] rx_at_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_link_xcvr #(.TIMEOUT_CYC(TO_CYC)) u0 (.*);

    always @(negedge clk) begin
        if (done_o) begin n_done++; rx_at_done = rx_byte_o; end
        if (warn_o) n_warn++;
        if (err_o)  n_err++;
        if (sdata_oe_o) n_oe++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // mode 0: normal ack, 1: ack never asserted, 2: ack stuck low
    task automatic xfer(input int mode, input logic dir, input logic [7:0] tx,
                        input logic [7:0] prx, input logic [7:0] exp_rx,
                        input logic stray_start);
        logic [7:0] seen;
        n_done = 0; n_warn = 0; n_err = 0; n_oe = 0;
        @(negedge clk);
        start_i = 1'b1; dir_out_i = dir; tx_byte_i = tx;
        @(negedge clk);
        start_i = 1'b0; tx_byte_i = 8'h00;
        for (int k = 0; k < 10 && req_n_o; k++) @(negedge clk);
        check("R3 req low after start", req_n_o, 0);
        if (mode != 1) ack_n_i = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sdata_i = prx[i];
            repeat (4) @(negedge clk);
            seen[i] = sdata_o;
            if (stray_start && i == 4) begin
                start_i = 1'b1; dir_out_i = ~dir; tx_byte_i = 8'hFF;
                @(negedge clk);
                start_i = 1'b0;
            end
            sclk_i = 1'b1;
            repeat (4) @(negedge clk);
            sclk_i = 1'b0;
        end
        for (int k = 0; k < 10 && !req_n_o; k++) @(negedge clk);
        check("R7 req released", req_n_o, 1);
        if (mode == 0) begin
            repeat (2) @(negedge clk);
            ack_n_i = 1'b1;
        end
        for (int k = 0; k < TO_CYC + 20 && !idle_o; k++) @(negedge clk);
        @(negedge clk);
        check("R8 done count", n_done, (mode == 2) ? 0 : 1);
        check("R9 warn count", n_warn, (mode == 1) ? 1 : 0);
        check("R10 err count", n_err, (mode == 2) ? 1 : 0);
        check("R5/R6 rx byte", rx_byte_o, exp_rx);
        if (dir) begin
            check("R4 sent bits", seen, tx);
            check("R4 oe active", n_oe > 0, 1);
        end else begin
            check("R5 oe quiet on inbound", n_oe, 0);
        end
        ack_n_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // {mode[1:0], dir, tx[7:0], peer rx[7:0]}
    localparam logic [18:0] VEC [0:5] = '{
        {2'd0, 1'b1, 8'hA5, 8'h00},
        {2'd0, 1'b0, 8'h00, 8'h3C},
        {2'd0, 1'b1, 8'h81, 8'hFF},
        {2'd0, 1'b0, 8'h00, 8'hFE},
        {2'd0, 1'b0, 8'h00, 8'h01},
        {2'd0, 1'b1, 8'h7E, 8'h55}
    };

    initial begin
        logic [7:0] model_rx;
        model_rx = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 req high", req_n_o, 1);
        check("R1 idle", idle_o, 1);
        check("R1 oe low", sdata_oe_o, 0);
        check("R1 pulses low", {done_o, warn_o, err_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int v = 0; v < 6; v++) begin
            if (!VEC[v][16]) model_rx = VEC[v][7:0];
            xfer(int'(VEC[v][18:17]), VEC[v][16], VEC[v][15:8], VEC[v][7:0],
                 model_rx, 1'b0);
        end

        // R11: idle clock edges ignored
        for (int i = 0; i < 5; i++) begin
            sclk_i = 1'b1; repeat (4) @(negedge clk);
            sclk_i = 1'b0; repeat (4) @(negedge clk);
        end
        check("R11 idle after stray clocks", idle_o, 1);
        model_rx = 8'hC3;
        xfer(0, 1'b0, 8'h00, 8'hC3, model_rx, 1'b0);

        // R2: start while busy ignored
        xfer(0, 1'b1, 8'h96, 8'h00, model_rx, 1'b1);
        model_rx = 8'h5A;
        xfer(0, 1'b0, 8'h00, 8'h5A, model_rx, 1'b1);

        // R9: ack never asserted
        xfer(1, 1'b1, 8'h33, 8'h00, model_rx, 1'b0);
        // R10: ack stuck low
        model_rx = 8'h99;
        xfer(2, 1'b0, 8'h00, 8'h99, model_rx, 1'b0);
        check("R10 idle after timeout", idle_o, 1);
        // recovery after timeout
        xfer(0, 1'b1, 8'h0F, 8'h00, model_rx, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule